// File: doc/BRIEF.md
# Coprocessor Shared-RAM Window

This block gives a host a small register window into a coprocessor's local byte-wide RAM. The host first loads a 16-bit pointer one byte at a time, through a low-byte register and a high-byte register. It then moves bytes through a single data register. When auto-increment is on, each data access steps the pointer by one. A whole block can therefore be uploaded, read back or compared after only one pointer load.

A status/control register sits in the same window. It holds the coprocessor run and bypass controls and the auto-increment enable. It also holds a host-to-coprocessor doorbell bit. Two coprocessor-raised attention flags share one host interrupt line. The host reads the status register to learn which flag is pending, and writes a one to a flag to acknowledge it.

The coprocessor reaches the same RAM through a plain request/grant port. Host data accesses always win. A coprocessor request that collides with one is held off for that cycle.

Top module: `copro_ram_window`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0x0000 and every status/control bit is 0. As a result host_int, cop_run, cop_bypass and cop_irq are all low.
- R2: Register select 0 loads the pointer's low byte and register select 1 loads its high byte. A host read of select 0 or select 1 returns that byte of the pointer.
- R3: A host write to register select 2 stores the byte at the pointer's RAM location. A host read of select 2 returns that location's byte on host_rdata during the cycle after the read strobe.
- R4: When the auto-increment bit is 1, every host data access (read or write) advances the pointer by one, wrapping from 0xFFFF to 0x0000. When the bit is 0, the pointer is unchanged by data accesses.
- R5: Register select 3 is the status/control register. Its bit layout is: bit0 run, bit1 auto-increment, bit2 bypass, bit3 doorbell, bit4 attention flag A, bit5 attention flag B, and bits 7:6 read as 0. A host write loads bits 0 to 2 directly, and cop_run and cop_bypass follow bits 0 and 2.
- R6: Writing 1 to bit3 sets the doorbell (cop_irq), and writing 0 leaves it unchanged. A cop_irq_ack pulse clears the doorbell, but a host set in the same cycle wins over the acknowledge.
- R7: A pulse on cop_int_set[0] sets flag A (bit4), and a pulse on cop_int_set[1] sets flag B (bit5). host_int is high whenever either flag is set.
- R8: A host write with 1 in bit4 or bit5 clears that flag, and 0 leaves it unchanged. A coprocessor set in the same cycle as a host clear leaves the flag set.
- R9: A coprocessor request is granted (cop_gnt high) in any cycle without a host data access, and is refused in a cycle with one. A granted write is stored. A granted read returns its byte on cop_rdata in the next cycle. Bytes written by one side are visible to the other.
- R10: The RAM is addressed by the low RAM_AW bits of the pointer (8 bits by default), so pointer values that differ only above those bits select the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 status/control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read result, valid the cycle after the strobe |
| host_int | output | 1 | Host interrupt, OR of both attention flags |
| cop_run | output | 1 | Coprocessor run control |
| cop_bypass | output | 1 | Coprocessor bypass control |
| cop_irq | output | 1 | Doorbell towards the coprocessor |
| cop_irq_ack | input | 1 | Doorbell acknowledge pulse |
| cop_int_set | input | 2 | Set pulses for attention flags A (bit0) and B (bit1) |
| cop_req | input | 1 | Coprocessor RAM request |
| cop_we | input | 1 | Coprocessor write enable |
| cop_addr | input | RAM_AW | Coprocessor RAM address |
| cop_wdata | input | 8 | Coprocessor write byte |
| cop_gnt | output | 1 | Request accepted this cycle |
| cop_rdata | output | 8 | Coprocessor read byte, cycle after grant |

## Verification
A pointer that drifts by even one step shows up on the very next data read. In a block transfer it shifts every later byte, so a full 256-byte write-then-read sweep with a position-dependent pattern exposes the fault within one pass. The same holds for a missing wrap or a wrong alias. A flag with the wrong set or clear priority is visible on host_int and on a status read in the cycle after the colliding pulses. A wrong arbitration choice shows on cop_gnt within the conflicting cycle, or as a lost byte on the following readback.

// File: rtl/cwin_pkg.sv
// Shared definitions for the coprocessor RAM window: register selects and
// the status/control bit layout. Assumes an 8-bit host data path.
package cwin_pkg;

    typedef enum logic [1:0] {
        SEL_PTR_LO = 2'd0,
        SEL_PTR_HI = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_CTRL   = 2'd3
    } cwin_sel_e;

    // Status/control image, LSB first: run, autoinc, bypass, doorbell, A, B
    typedef struct packed {
        logic flag_b;
        logic flag_a;
        logic doorbell;
        logic bypass;
        logic autoinc;
        logic run;
    } cwin_ctrl_t;

    localparam int CTRL_W = $bits(cwin_ctrl_t);

endpackage

// File: rtl/cwin_addr_ptr.sv
// Host address pointer. Loads low and high bytes separately and steps by
// one on request, wrapping at PTR_W bits. Assumes PTR_W > 8 and that at
// most one of ld_lo, ld_hi and bump is high in a cycle.
module cwin_addr_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_lo,
    input  logic             ld_hi,
    input  logic [7:0]       wbyte,
    input  logic             bump,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 8;

    // Pointer register: byte loads or single-step advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_lo) begin
            ptr[7:0] <= wbyte;
        end else if (ld_hi) begin
            ptr[PTR_W-1:8] <= wbyte[HI_W-1:0];
        end else if (bump) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R4: a step moves the pointer forward by exactly one
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !ld_lo && !ld_hi) |=> (ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/cwin_ctrl_regs.sv
// Status/control register. Run, autoinc and bypass are plain loads. The
// doorbell is set by the host and cleared by a coprocessor acknowledge
// (a host set wins). Attention flags are set by the coprocessor and cleared
// by host write-one (a coprocessor set wins). Assumes pulses are one cycle.
module cwin_ctrl_regs
    import cwin_pkg::*;
#(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  cwin_ctrl_t       wval,
    input  logic             db_ack,
    input  logic [NFLAG-1:0] flag_set,
    output cwin_ctrl_t       st
);
    logic             run_q, ainc_q, byp_q, db_q;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_clr;

    assign flag_clr = {wval.flag_b, wval.flag_a};

    // Plain control bits: rewritten on every status/control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ainc_q <= 1'b0;
            byp_q  <= 1'b0;
        end else if (ctrl_wr) begin
            run_q  <= wval.run;
            ainc_q <= wval.autoinc;
            byp_q  <= wval.bypass;
        end
    end

    // Doorbell: host write-one sets, acknowledge clears, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            db_q <= 1'b0;
        end else if (ctrl_wr && wval.doorbell) begin
            db_q <= 1'b1;
        end else if (db_ack) begin
            db_q <= 1'b0;
        end
    end

    // Attention flags: coprocessor set beats host write-one clear
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (flag_set[g]) begin
                flag_q[g] <= 1'b1;
            end else if (ctrl_wr && flag_clr[g]) begin
                flag_q[g] <= 1'b0;
            end
        end
    end

    assign st = '{flag_b: flag_q[1], flag_a: flag_q[0], doorbell: db_q,
                  bypass: byp_q, autoinc: ainc_q, run: run_q};

    // R8: a set pulse always leaves the flag set
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set[0] |=> st.flag_a);

    // R8: a write-one clear without a colliding set clears the flag
    assert_clear_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wval.flag_a && !flag_set[0]) |=> !st.flag_a);

    // R6: an acknowledge without a colliding host set drops the doorbell
    assert_db_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (db_ack && !(ctrl_wr && wval.doorbell)) |=> !st.doorbell);

endmodule

// File: rtl/cwin_ram_arb.sv
// Single-port byte RAM shared by host and coprocessor. A host access wins
// the cycle; a coprocessor request is granted only when the host is idle.
// One registered read output serves whichever side read last.
module cwin_ram_arb #(
    parameter int RAM_AW = 8,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              host_acc,
    input  logic              host_we,
    input  logic [RAM_AW-1:0] host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic              cop_req,
    input  logic              cop_we,
    input  logic [RAM_AW-1:0] cop_addr,
    input  logic [DW-1:0]     cop_wdata,
    output logic              cop_gnt,
    output logic [DW-1:0]     rdata_q
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DW-1:0] mem [DEPTH];

    assign cop_gnt = cop_req & ~host_acc;

    // Storage and read register: host first, coprocessor when granted
    always_ff @(posedge clk) begin
        if (host_acc) begin
            if (host_we) mem[host_addr] <= host_wdata;
            else         rdata_q        <= mem[host_addr];
        end else if (cop_req) begin
            if (cop_we)  mem[cop_addr]  <= cop_wdata;
            else         rdata_q        <= mem[cop_addr];
        end
    end

endmodule

// File: rtl/copro_ram_window.sv
// Top of the coprocessor RAM window. Decodes the four host registers,
// drives the pointer, status/control and shared RAM, and registers host
// read data so it is valid for the cycle after the strobe.
module copro_ram_window
    import cwin_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [1:0]        host_reg,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_int,
    output logic              cop_run,
    output logic              cop_bypass,
    output logic              cop_irq,
    input  logic              cop_irq_ack,
    input  logic [1:0]        cop_int_set,
    input  logic              cop_req,
    input  logic              cop_we,
    input  logic [RAM_AW-1:0] cop_addr,
    input  logic [7:0]        cop_wdata,
    output logic              cop_gnt,
    output logic [7:0]        cop_rdata
);
    logic             sel_lo, sel_hi, sel_data, sel_ctrl;
    logic [PTR_W-1:0] ptr;
    cwin_ctrl_t       st;
    logic [7:0]       ram_q;
    logic [7:0]       reg_rd_q;
    logic             rd_ram_q;
    logic [7:0]       rd_mux;

    assign sel_lo   = host_cs && (host_reg == SEL_PTR_LO);
    assign sel_hi   = host_cs && (host_reg == SEL_PTR_HI);
    assign sel_data = host_cs && (host_reg == SEL_DATA);
    assign sel_ctrl = host_cs && (host_reg == SEL_CTRL);

    cwin_addr_ptr #(.PTR_W(PTR_W)) i_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (sel_lo && host_we),
        .ld_hi (sel_hi && host_we),
        .wbyte (host_wdata),
        .bump  (sel_data && st.autoinc),
        .ptr   (ptr)
    );

    cwin_ctrl_regs #(.NFLAG(2)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (sel_ctrl && host_we),
        .wval     (cwin_ctrl_t'(host_wdata[CTRL_W-1:0])),
        .db_ack   (cop_irq_ack),
        .flag_set (cop_int_set),
        .st       (st)
    );

    cwin_ram_arb #(.RAM_AW(RAM_AW), .DW(8)) i_ram (
        .clk        (clk),
        .host_acc   (sel_data),
        .host_we    (host_we),
        .host_addr  (ptr[RAM_AW-1:0]),
        .host_wdata (host_wdata),
        .cop_req    (cop_req),
        .cop_we     (cop_we),
        .cop_addr   (cop_addr),
        .cop_wdata  (cop_wdata),
        .cop_gnt    (cop_gnt),
        .rdata_q    (ram_q)
    );

    // Register-read source for the non-RAM selects
    always_comb begin
        unique case (host_reg)
            SEL_PTR_LO: rd_mux = ptr[7:0];
            SEL_PTR_HI: rd_mux = 8'(ptr[PTR_W-1:8]);
            SEL_CTRL:   rd_mux = 8'(st);
            default:    rd_mux = 8'h00;
        endcase
    end

    // Capture host read results; data reads take the RAM output instead
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rd_q <= 8'h00;
            rd_ram_q <= 1'b0;
        end else if (host_cs && !host_we) begin
            reg_rd_q <= rd_mux;
            rd_ram_q <= sel_data;
        end
    end

    assign host_rdata = rd_ram_q ? ram_q : reg_rd_q;
    assign cop_rdata  = ram_q;
    assign host_int   = st.flag_a | st.flag_b;
    assign cop_run    = st.run;
    assign cop_bypass = st.bypass;
    assign cop_irq    = st.doorbell;

    // R5: the run output follows bit0 of a status/control write
    assert_run_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs && host_we && host_reg == SEL_CTRL) |=> (cop_run == $past(host_wdata[0])));

    // R7: setting a flag raises the host line in the next cycle
    assert_int_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|cop_int_set) |=> host_int);

endmodule

// File: tb/test_copro_ram_window.sv
// Self-checking bench: full-RAM sweep, pointer wrap and alias, arbitration
// and flag priority cases, with expected values computed here.
module test_copro_ram_window;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs = 1'b0, host_we = 1'b0;
    logic [1:0] host_reg = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       host_int, cop_run, cop_bypass, cop_irq;
    logic       cop_irq_ack = 1'b0;
    logic [1:0] cop_int_set = 2'b00;
    logic       cop_req = 1'b0, cop_we = 1'b0;
    logic [7:0] cop_addr = 8'h00, cop_wdata = 8'h00;
    logic       cop_gnt;
    logic [7:0] cop_rdata;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    copro_ram_window i_copro_ram_window (
        .clk(clk), .rst_n(rst_n),
        .host_cs(host_cs), .host_we(host_we), .host_reg(host_reg),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_int(host_int),
        .cop_run(cop_run), .cop_bypass(cop_bypass), .cop_irq(cop_irq),
        .cop_irq_ack(cop_irq_ack), .cop_int_set(cop_int_set),
        .cop_req(cop_req), .cop_we(cop_we), .cop_addr(cop_addr),
        .cop_wdata(cop_wdata), .cop_gnt(cop_gnt), .cop_rdata(cop_rdata)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hwr(input logic [1:0] r, input logic [7:0] d);
        host_cs = 1'b1; host_we = 1'b1; host_reg = r; host_wdata = d;
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
    endtask

    task automatic hrd(input logic [1:0] r, output logic [7:0] d);
        host_cs = 1'b1; host_we = 1'b0; host_reg = r;
        @(negedge clk);
        host_cs = 1'b0;
        d = host_rdata;
    endtask

    task automatic setptr(input logic [15:0] p);
        hwr(2'd0, p[7:0]);
        hwr(2'd1, p[15:8]);
    endtask

    task automatic getptr(output logic [15:0] p);
        logic [7:0] lo, hi;
        hrd(2'd0, lo);
        hrd(2'd1, hi);
        p = {hi, lo};
    endtask

    task automatic cop_acc(input logic w, input logic [7:0] a, input logic [7:0] d,
                           output logic [7:0] q);
        cop_req = 1'b1; cop_we = w; cop_addr = a; cop_wdata = d;
        @(negedge clk);
        cop_req = 1'b0; cop_we = 1'b0;
        q = cop_rdata;
    endtask

    task automatic pulse_set(input logic [1:0] s);
        cop_int_set = s;
        @(negedge clk);
        cop_int_set = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        hrd(2'd3, d);  check("R1 ctrl", {8'h0, d}, 16'h0000);
        getptr(p);     check("R1 ptr", p, 16'h0000);
        check("R1 outputs", {12'h0, host_int, cop_run, cop_bypass, cop_irq}, 16'h0000);

        // R2: pointer byte loads and readback
        setptr(16'h12A4);
        getptr(p);     check("R2 ptr", p, 16'h12A4);
        hwr(2'd1, 8'h7E);
        getptr(p);     check("R2 hi only", p, 16'h7EA4);

        // R5: control bits and outputs
        hwr(2'd3, 8'h07);
        check("R5 run/byp", {14'h0, cop_run, cop_bypass}, 16'h0003);
        hrd(2'd3, d);  check("R5 ctrl read", {8'h0, d}, 16'h0007);
        hwr(2'd3, 8'hC2);
        hrd(2'd3, d);  check("R5 upper bits read 0", {8'h0, d}, 16'h0002);
        check("R5 run/byp cleared", {14'h0, cop_run, cop_bypass}, 16'h0000);

        // R3/R4: full sweep with auto-increment
        hwr(2'd3, 8'h03);
        setptr(16'h0000);
        for (int i = 0; i < 256; i++) hwr(2'd2, 8'((i * 37 + 11) & 8'hFF));
        getptr(p);     check("R4 after write sweep", p, 16'h0100);
        setptr(16'h0000);
        for (int i = 0; i < 256; i++) begin
            hrd(2'd2, d);
            check("R3 sweep read", {8'h0, d}, {8'h0, 8'((i * 37 + 11) & 8'hFF)});
        end
        getptr(p);     check("R4 after read sweep", p, 16'h0100);

        // R4: auto-increment off leaves the pointer alone
        hwr(2'd3, 8'h01);
        setptr(16'h0005);
        hwr(2'd2, 8'hAA);
        hrd(2'd2, d);  check("R3 no-inc read", {8'h0, d}, 16'h00AA);
        getptr(p);     check("R4 no-inc ptr", p, 16'h0005);

        // R4/R10: wrap at 0xFFFF, byte lands at RAM 0xFF
        hwr(2'd3, 8'h03);
        setptr(16'hFFFF);
        hwr(2'd2, 8'h5C);
        getptr(p);     check("R4 wrap", p, 16'h0000);
        cop_acc(1'b0, 8'hFF, 8'h00, d);
        check("R10 wrap byte", {8'h0, d}, 16'h005C);

        // R10: alias through upper pointer bits
        setptr(16'h1234);
        hwr(2'd2, 8'h99);
        cop_acc(1'b0, 8'h34, 8'h00, d);
        check("R10 alias", {8'h0, d}, 16'h0099);

        // R9: coprocessor write visible to host
        cop_acc(1'b1, 8'h10, 8'h77, d);
        setptr(16'h0310);
        hrd(2'd2, d);  check("R9 cop write", {8'h0, d}, 16'h0077);

        // R9: conflict stalls the coprocessor for one cycle
        setptr(16'h0020);
        host_cs = 1'b1; host_we = 1'b1; host_reg = 2'd2; host_wdata = 8'h3D;
        cop_req = 1'b1; cop_we = 1'b1; cop_addr = 8'h21; cop_wdata = 8'h4E;
        #1;
        check("R9 stall", {15'h0, cop_gnt}, 16'h0000);
        @(negedge clk);
        host_cs = 1'b0; host_we = 1'b0;
        #1;
        check("R9 grant after", {15'h0, cop_gnt}, 16'h0001);
        @(negedge clk);
        cop_req = 1'b0; cop_we = 1'b0;
        setptr(16'h0020);
        hrd(2'd2, d);  check("R9 host byte kept", {8'h0, d}, 16'h003D);
        hrd(2'd2, d);  check("R9 cop byte stored", {8'h0, d}, 16'h004E);

        // R6: doorbell set, write-zero ignored, acknowledge, collision
        hwr(2'd3, 8'h0B);
        check("R6 set", {15'h0, cop_irq}, 16'h0001);
        hwr(2'd3, 8'h03);
        check("R6 zero ignored", {15'h0, cop_irq}, 16'h0001);
        cop_irq_ack = 1'b1; @(negedge clk); cop_irq_ack = 1'b0;
        check("R6 ack clears", {15'h0, cop_irq}, 16'h0000);
        cop_irq_ack = 1'b1;
        hwr(2'd3, 8'h0B);
        cop_irq_ack = 1'b0;
        check("R6 set beats ack", {15'h0, cop_irq}, 16'h0001);
        cop_irq_ack = 1'b1; @(negedge clk); cop_irq_ack = 1'b0;

        // R7/R8: attention flags
        pulse_set(2'b01);
        check("R7 flag A line", {15'h0, host_int}, 16'h0001);
        hrd(2'd3, d);  check("R7 flag A status", {8'h0, d}, 16'h0013);
        hwr(2'd3, 8'h03);
        hrd(2'd3, d);  check("R8 zero keeps", {8'h0, d}, 16'h0013);
        hwr(2'd3, 8'h13);
        check("R8 clear A", {15'h0, host_int}, 16'h0000);
        pulse_set(2'b10);
        hrd(2'd3, d);  check("R7 flag B status", {8'h0, d}, 16'h0023);
        pulse_set(2'b01);
        hwr(2'd3, 8'h13);
        check("R7 B holds line", {15'h0, host_int}, 16'h0001);
        hrd(2'd3, d);  check("R8 clear A only", {8'h0, d}, 16'h0023);
        cop_int_set = 2'b10;
        hwr(2'd3, 8'h23);
        cop_int_set = 2'b00;
        hrd(2'd3, d);  check("R8 set beats clear", {8'h0, d}, 16'h0023);
        hwr(2'd3, 8'h23);
        check("R8 final clear", {15'h0, host_int}, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule